// File: doc/BRIEF.md
# Dword-to-Halfword Disk Data Port Bridge

This block connects a host register bus carrying 32-bit words to a 16-bit parallel disk data port shared by two channels. A host request whose address matches a channel's data port is turned into timed device cycles on that channel. Each device cycle drives a per-channel chip select, a read or write strobe, and the 16-bit data bus.

When dword mode is enabled, one host word becomes two device cycles in sequence: the low half moves first and the high half second. On reads the two halves are merged in a staging register and returned as a single response. When dword mode is off, only one device cycle runs. Strobe width and recovery length are programmable in clocks. A timing-mode input chooses between compatible timing, which holds chip selects off for a fixed gap between the halves, and enhanced timing, which starts the second half as soon as the first recovery ends.

The host side has two streams: requests (req_valid/req_ready) and responses (rsp_valid/rsp_ready). A request is accepted on a clock edge where both req_valid and req_ready are high. req_ready is high only while the bridge is idle, so at most one request is in flight. A response stays valid, with stable data, until rsp_ready is seen high. The bridge accepts no new request until that response has been taken.

Top module: `pio_dword_bridge`

## Requirements
- R1: Address 0x01F0 selects channel 0 and drives dev_cs_n[0] low. Address 0x0170 selects channel 1 and drives dev_cs_n[1] low. At most one chip select is low at any time.
- R2: A request to any other address is accepted and answered with rsp_rdata equal to zero. No chip select or strobe becomes active.
- R3: With cfg_dword_en high, a data port access runs exactly two device cycles. Data bits 15:0 move in the first cycle and bits 31:16 in the second.
- R4: On a dword read, the device word sampled in the first cycle appears in rsp_rdata[15:0] and the one from the second cycle in rsp_rdata[31:16]. Both arrive in one response. The device word is sampled on the clock edge that ends the strobe.
- R5: With cfg_dword_en low, a data port access runs one device cycle. A write then puts out bits 15:0 only, and a read returns zero in bits 31:16.
- R6: The strobe stays low for cfg_active_clks clocks. After it rises, the chip select stays low for cfg_recovery_clks clocks. A programmed value of zero acts as one.
- R7: With cfg_enhanced low (compatible timing), all chip selects stay high for at least GAP_CLKS clocks (default 2) between the two halves of a dword access.
- R8: With cfg_enhanced high (enhanced timing), the chip select stays low from the first half to the second, and the second strobe falls right after the first recovery.
- R9: req_ready is low from acceptance until the response has been taken, and rsp_valid rises only after the final device cycle, including its recovery, has finished.
- R10: While rsp_valid is high and rsp_ready is low, rsp_valid stays high, rsp_rdata stays unchanged, and no request is accepted.
- R11: During a write cycle dev_doe is high and dev_dout carries the current half. dev_dout does not change while dev_wr_n is low.
- R12: After reset all chip selects and strobes are high, dev_doe is low, req_ready is high and rsp_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Bridge idle and able to accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW (16) | Host I/O address |
| req_wdata | input | 2*DW (32) | Host write word |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Host takes the response |
| rsp_rdata | output | 2*DW (32) | Read word; zero for writes and misses |
| cfg_dword_en | input | 1 | 1 = split each access into two halves |
| cfg_enhanced | input | 1 | 1 = enhanced timing, 0 = compatible timing |
| cfg_active_clks | input | CW (4) | Strobe low time in clocks |
| cfg_recovery_clks | input | CW (4) | Recovery time in clocks |
| dev_cs_n | output | NCH (2) | Per-channel chip selects, active low |
| dev_rd_n | output | 1 | Read strobe, active low |
| dev_wr_n | output | 1 | Write strobe, active low |
| dev_dout | output | DW (16) | Device write data |
| dev_doe | output | 1 | Device data output enable |
| dev_din | input | DW (16) | Device read data |

## Verification
The assertions check these rules on every cycle: chip selects are one-hot, a strobe is never active without its chip select, the bridge does not accept a request while a device cycle runs, a waiting response holds steady, write data is stable under the strobe, and the compatible-mode chip-select gap and the enhanced-mode continuity hold. Some behaviours are shown only by the bench scenarios. These are the half ordering and the merge of read data, the number of device cycles for each mode and address, the exact strobe and recovery lengths including the zero settings, and the zero upper half in single-cycle mode.

// File: rtl/pio_bridge_pkg.sv
package pio_bridge_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ACT,
    ST_REC,
    ST_GAP,
    ST_RESP
  } phase_e;

  localparam int NCH = 2;

  // Data port address of each channel; index = channel number.
  function automatic logic [15:0] port_addr(input int ch);
    return (ch == 0) ? 16'h01F0 : 16'h0170;
  endfunction

endpackage

// File: rtl/pio_port_decode.sv
module pio_port_decode
  import pio_bridge_pkg::*;
#(
  parameter int AW  = 16,
  parameter int CHW = 1
) (
  input  logic [AW-1:0]  addr,
  output logic           hit,
  output logic [CHW-1:0] ch_idx
);

  logic [NCH-1:0] sel;

  for (genvar i = 0; i < NCH; i++) begin : g_chan
    assign sel[i] = (addr == AW'(port_addr(i)));
  end

  assign hit = |sel;

  always_comb begin
    ch_idx = '0;
    for (int i = 0; i < NCH; i++) begin
      if (sel[i]) ch_idx = CHW'(i);
    end
  end

endmodule

// File: rtl/pio_cycle_timer.sv
module pio_cycle_timer #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          done
);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign done = (cnt == '0);

  // The timer can only leave its expired state through a load.
  p_reload_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(done) |-> $past(load));

endmodule

// File: rtl/pio_read_stage.sv
module pio_read_stage #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          capture,
  input  logic          upper,
  input  logic [DW-1:0] din,
  output logic [2*DW-1:0] word
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word <= '0;
    end else if (clear) begin
      word <= '0;
    end else if (capture) begin
      if (upper) word[2*DW-1:DW] <= din;
      else       word[DW-1:0]    <= din;
    end
  end

  // The high half is written only by a second-half capture.
  p_upper_only_second_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && !(capture && upper)) |=> $stable(word[2*DW-1:DW]));

endmodule

// File: rtl/pio_dword_bridge.sv
module pio_dword_bridge
  import pio_bridge_pkg::*;
#(
  parameter int AW       = 16,
  parameter int DW       = 16,
  parameter int CW       = 4,
  parameter int GAP_CLKS = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic            req_write,
  input  logic [AW-1:0]   req_addr,
  input  logic [2*DW-1:0] req_wdata,
  output logic            rsp_valid,
  input  logic            rsp_ready,
  output logic [2*DW-1:0] rsp_rdata,
  input  logic            cfg_dword_en,
  input  logic            cfg_enhanced,
  input  logic [CW-1:0]   cfg_active_clks,
  input  logic [CW-1:0]   cfg_recovery_clks,
  output logic [NCH-1:0]  dev_cs_n,
  output logic            dev_rd_n,
  output logic            dev_wr_n,
  output logic [DW-1:0]   dev_dout,
  output logic            dev_doe,
  input  logic [DW-1:0]   dev_din
);

  localparam int HW  = 2 * DW;
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1;
  localparam logic [CW-1:0] GAP_LOAD = CW'(GAP_CLKS - 1);

  function automatic logic [CW-1:0] span(input logic [CW-1:0] v);
    return (v == '0) ? '0 : v - 1'b1;
  endfunction

  phase_e          st, st_n;
  logic            wr_q, dword_q, enh_q, half_q;
  logic [CHW-1:0]  ch_q;
  logic [HW-1:0]   wdata_q;
  logic [CW-1:0]   act_q, rec_q;

  logic            hit_d;
  logic [CHW-1:0]  ch_d;
  logic            accept;
  logic            tmr_load, tmr_done, cap;
  logic [CW-1:0]   tmr_val;
  logic            in_cyc;

  pio_port_decode #(.AW(AW), .CHW(CHW)) u_decode (
    .addr   (req_addr),
    .hit    (hit_d),
    .ch_idx (ch_d)
  );

  pio_cycle_timer #(.CW(CW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .done     (tmr_done)
  );

  assign req_ready = (st == ST_IDLE);
  assign accept    = req_valid && req_ready;

  always_comb begin
    st_n     = st;
    tmr_load = 1'b0;
    tmr_val  = '0;
    cap      = 1'b0;
    unique case (st)
      ST_IDLE: if (accept) begin
        if (hit_d) begin
          st_n     = ST_ACT;
          tmr_load = 1'b1;
          tmr_val  = span(cfg_active_clks);
        end else begin
          st_n = ST_RESP;
        end
      end
      ST_ACT: if (tmr_done) begin
        cap      = 1'b1;
        st_n     = ST_REC;
        tmr_load = 1'b1;
        tmr_val  = span(rec_q);
      end
      ST_REC: if (tmr_done) begin
        if (!half_q && dword_q) begin
          tmr_load = 1'b1;
          if (enh_q) begin
            st_n    = ST_ACT;
            tmr_val = span(act_q);
          end else begin
            st_n    = ST_GAP;
            tmr_val = GAP_LOAD;
          end
        end else begin
          st_n = ST_RESP;
        end
      end
      ST_GAP: if (tmr_done) begin
        st_n     = ST_ACT;
        tmr_load = 1'b1;
        tmr_val  = span(act_q);
      end
      ST_RESP: if (rsp_ready) st_n = ST_IDLE;
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      wr_q    <= 1'b0;
      dword_q <= 1'b0;
      enh_q   <= 1'b0;
      half_q  <= 1'b0;
      ch_q    <= '0;
      wdata_q <= '0;
      act_q   <= '0;
      rec_q   <= '0;
    end else begin
      st <= st_n;
      if (accept) begin
        wr_q    <= req_write;
        dword_q <= cfg_dword_en;
        enh_q   <= cfg_enhanced;
        half_q  <= 1'b0;
        ch_q    <= ch_d;
        wdata_q <= req_wdata;
        act_q   <= cfg_active_clks;
        rec_q   <= cfg_recovery_clks;
      end else if ((st == ST_REC || st == ST_GAP) && st_n == ST_ACT) begin
        half_q <= 1'b1;
      end
    end
  end

  pio_read_stage #(.DW(DW)) u_stage (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (accept),
    .capture (cap && !wr_q),
    .upper   (half_q),
    .din     (dev_din),
    .word    (rsp_rdata)
  );

  assign in_cyc = (st == ST_ACT) || (st == ST_REC);

  for (genvar i = 0; i < NCH; i++) begin : g_cs
    assign dev_cs_n[i] = !(in_cyc && ch_q == CHW'(i));
  end

  assign dev_rd_n  = !(st == ST_ACT && !wr_q);
  assign dev_wr_n  = !(st == ST_ACT && wr_q);
  assign dev_doe   = in_cyc && wr_q;
  assign dev_dout  = half_q ? wdata_q[HW-1:DW] : wdata_q[DW-1:0];
  assign rsp_valid = (st == ST_RESP);

  // Assertion support: run of clocks with every chip select high.
  logic       cs_act, cs_act_d;
  logic [3:0] idle_run;
  assign cs_act = !(&dev_cs_n);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_act_d <= 1'b0;
      idle_run <= 4'hF;
    end else begin
      cs_act_d <= cs_act;
      if (cs_act)              idle_run <= '0;
      else if (idle_run != 4'hF) idle_run <= idle_run + 1'b1;
    end
  end

  p_cs_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~dev_cs_n));

  p_strobe_needs_cs_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!dev_rd_n || !dev_wr_n) |-> cs_act);

  p_no_accept_in_cycle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cs_act |-> !req_ready);

  p_rsp_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata) && !req_ready));

  p_wdata_stable_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!dev_wr_n && $past(!dev_wr_n)) |-> $stable(dev_dout));

  p_compat_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_act && !cs_act_d && half_q && !enh_q) |-> (idle_run >= 4'(GAP_CLKS)));

  p_enh_continuous_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_REC && tmr_done && !half_q && dword_q && enh_q) |=> (cs_act && (!dev_rd_n || !dev_wr_n)));

endmodule

// File: tb/pio_dword_bridge_tb.sv
module pio_dword_bridge_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic        req_ready;
  logic [15:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid, rsp_ready = 1'b1;
  logic [31:0] rsp_rdata;
  logic        cfg_dword_en = 1'b1, cfg_enhanced = 1'b0;
  logic [3:0]  cfg_active_clks = 4'd3, cfg_recovery_clks = 4'd2;
  logic [1:0]  dev_cs_n;
  logic        dev_rd_n, dev_wr_n, dev_doe;
  logic [15:0] dev_dout, dev_din;

  always #2 clk = ~clk;

  pio_dword_bridge u_dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata),
    .cfg_dword_en(cfg_dword_en), .cfg_enhanced(cfg_enhanced),
    .cfg_active_clks(cfg_active_clks), .cfg_recovery_clks(cfg_recovery_clks),
    .dev_cs_n(dev_cs_n), .dev_rd_n(dev_rd_n), .dev_wr_n(dev_wr_n),
    .dev_dout(dev_dout), .dev_doe(dev_doe), .dev_din(dev_din)
  );

  int total = 0, bad = 0;
  bit finished = 0;

  task automatic chk(bit ok, string rq, longint actual, longint expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", rq, actual, expv);
    end
  endtask

  // Device model: read data encodes channel and read sequence number.
  int rd_num = 0;
  assign dev_din = {(!dev_cs_n[1]) ? 8'h5B : 8'hC3, rd_num[7:0]};

  // Scoreboard queues.
  logic [31:0] exp_q[$];
  logic [16:0] wr_exp_q[$];

  // Monitor state.
  int   strobe_cnt = 0, low_len = 0, last_w = 0, gap_hi = 0, rec_hi = 0;
  int   busy_viol = 0, rsp_cnt = 0;
  logic [1:0] cs_seen = '0;
  bit   prev_rd = 0, prev_wr = 0;
  logic [16:0] wr_seen;
  bit   wr_doe;

  always @(negedge clk) begin
    if (rst_n) begin
      bit strobe, cs_act;
      strobe = !dev_rd_n || !dev_wr_n;
      cs_act = !(&dev_cs_n);
      cs_seen |= ~dev_cs_n;
      if (cs_act && req_ready) busy_viol++;
      if (strobe) begin
        low_len++;
        if (!dev_wr_n) begin
          wr_seen = {!dev_cs_n[1], dev_dout};
          wr_doe  = dev_doe;
        end
      end else if (prev_rd || prev_wr) begin
        strobe_cnt++;
        last_w  = low_len;
        low_len = 0;
        if (prev_rd) rd_num++;
        if (prev_wr) begin
          if (wr_exp_q.size() == 0) chk(0, "R11 unexpected write", wr_seen, 0);
          else begin
            logic [16:0] e;
            e = wr_exp_q.pop_front();
            chk(wr_seen == e, "R3/R11 write half", wr_seen, e);
            chk(wr_doe, "R11 doe during write", wr_doe, 1);
          end
        end
      end
      if (strobe_cnt == 1 && !strobe) begin
        if (cs_act) rec_hi++;
        else        gap_hi++;
      end
      prev_rd = !dev_rd_n;
      prev_wr = !dev_wr_n;
      if (rsp_valid && rsp_ready) begin
        if (exp_q.size() == 0) chk(0, "R9 unexpected response", rsp_rdata, 0);
        else begin
          logic [31:0] e;
          e = exp_q.pop_front();
          chk(rsp_rdata == e, "R4/R5/R2 response data", rsp_rdata, e);
        end
        rsp_cnt++;
      end
    end
  end

  int rd_pred = 0;

  task automatic run(bit wr, logic [15:0] addr, logic [31:0] wd, bit dw, bit enh,
                     logic [3:0] a, logic [3:0] r, bit bp);
    bit hit, ch;
    int nstr, aw, rw, c0;
    logic [31:0] e, held;
    hit  = (addr == 16'h01F0) || (addr == 16'h0170);
    ch   = (addr == 16'h0170);
    nstr = hit ? (dw ? 2 : 1) : 0;
    aw   = (a == 0) ? 1 : a;
    rw   = (r == 0) ? 1 : r;
    e = '0;
    if (hit && !wr) begin
      e[15:0] = {ch ? 8'h5B : 8'hC3, 8'(rd_pred)};
      if (dw) e[31:16] = {ch ? 8'h5B : 8'hC3, 8'(rd_pred + 1)};
      rd_pred += nstr;
    end
    if (hit && wr) begin
      wr_exp_q.push_back({ch, wd[15:0]});
      if (dw) wr_exp_q.push_back({ch, wd[31:16]});
    end
    exp_q.push_back(e);
    @(negedge clk);
    cfg_dword_en = dw; cfg_enhanced = enh;
    cfg_active_clks = a; cfg_recovery_clks = r;
    strobe_cnt = 0; gap_hi = 0; rec_hi = 0; cs_seen = '0; busy_viol = 0;
    if (bp) rsp_ready = 1'b0;
    c0 = rsp_cnt;
    req_valid = 1'b1; req_write = wr; req_addr = addr; req_wdata = wd;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    if (bp) begin
      while (!rsp_valid) @(negedge clk);
      held = rsp_rdata;
      for (int k = 0; k < 4; k++) begin
        @(negedge clk);
        chk(rsp_valid && rsp_rdata == held && !req_ready, "R10 hold under back-pressure",
            {rsp_valid, req_ready, rsp_rdata}, {1'b1, 1'b0, held});
      end
      rsp_ready = 1'b1;
    end
    while (rsp_cnt == c0) @(negedge clk);
    repeat (2) @(negedge clk);
    chk(strobe_cnt == nstr, "R3/R5/R2 device cycle count", strobe_cnt, nstr);
    chk(cs_seen == (hit ? (ch ? 2'b10 : 2'b01) : 2'b00), "R1/R2 channel select", cs_seen,
        hit ? (ch ? 2 : 1) : 0);
    chk(busy_viol == 0, "R9 ready low while busy", busy_viol, 0);
    if (hit) begin
      chk(last_w == aw, "R6 strobe width", last_w, aw);
      chk(rec_hi == rw, "R6 recovery length", rec_hi, rw);
    end
    if (hit && dw) begin
      if (enh) chk(gap_hi == 0, "R8 no chip-select gap", gap_hi, 0);
      else     chk(gap_hi == 2, "R7 compatible gap", gap_hi, 2);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(dev_cs_n == 2'b11 && dev_rd_n && dev_wr_n && !dev_doe && !req_ready == 0 && !rsp_valid,
        "R12 reset state", {dev_cs_n, dev_rd_n, dev_wr_n, dev_doe, req_ready, rsp_valid}, 7'b1111010);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(req_ready && !rsp_valid && dev_cs_n == 2'b11, "R12 idle after reset",
        {req_ready, rsp_valid}, 2'b10);

    run(1, 16'h01F0, 32'hBEEF_1234, 1, 0, 4'd3, 4'd2, 0); // R3 R7 R11
    run(0, 16'h0170, 32'h0,         1, 0, 4'd3, 4'd2, 0); // R4 R1
    run(0, 16'h01F0, 32'h0,         1, 1, 4'd3, 4'd2, 0); // R8 R4
    run(1, 16'h0170, 32'hCAFE_5A5A, 1, 1, 4'd2, 4'd3, 0); // R8 R11
    run(0, 16'h01F0, 32'h0,         0, 0, 4'd3, 4'd2, 0); // R5 read
    run(1, 16'h0170, 32'h7777_0F0F, 0, 1, 4'd3, 4'd2, 0); // R5 write
    run(0, 16'h03F6, 32'h0,         1, 0, 4'd3, 4'd2, 0); // R2
    run(1, 16'h01F1, 32'hFFFF_FFFF, 1, 0, 4'd3, 4'd2, 0); // R2
    run(0, 16'h0170, 32'h0,         1, 0, 4'd0, 4'd0, 0); // R6 zero settings
    run(1, 16'h01F0, 32'h1357_9BDF, 1, 1, 4'd5, 4'd4, 0); // R6 long settings
    run(0, 16'h01F0, 32'h0,         1, 0, 4'd3, 4'd2, 1); // R10
    run(0, 16'h0170, 32'h0,         0, 0, 4'd1, 4'd1, 1); // R10 R5

    chk(exp_q.size() == 0 && wr_exp_q.size() == 0, "R9 scoreboard drained",
        exp_q.size() + wr_exp_q.size(), 0);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule